// File: doc/BRIEF.md
# Write-Protected Oscillator Control Register

This block is one 8-bit memory-mapped control register. It holds the enables for three oscillator sources, two enables for clock-failure detection, a flash power-down request and a 2-bit system clock source select. Each field drives its own output pin. These pins go to the clock monitor and the oscillator enables, which sit outside this block. Software reads the register at any time. Before a store is accepted, software must write a two-byte key to the same address. The register then accepts exactly one store and locks itself again.

The bus is a plain synchronous register port with an address, a write strobe, write data and read data. Every access completes in one cycle, so the port has no valid/ready handshake and never applies back-pressure. Read data is combinational from the address. A write that is accepted on a clock edge appears on the field pins and on the read data after that same edge.

A synchronous active-low reset loads the default value. An option input selects the reset value of the flash power-down field.

Top module: `osc_ctrl_reg`

## Requirements
- R1: While reset is active, the register loads 0xA0 if the option input is 1, and 0xA4 if the option input is 0. In both cases the internal and watchdog oscillator enables are 1, the failure-detection enables are 0, and the clock select is 0.
- R2: The field pins follow the stored byte as follows: bit 7 is the internal oscillator enable, bit 6 the crystal enable, bit 5 the watchdog oscillator enable, bit 4 the primary failure-detect enable, bit 3 the watchdog failure-detect enable, bit 2 the flash power-down, and bits 1:0 the clock select.
- R3: When the address is 0xF86, read data equals the stored byte, whether the register is locked or not. At any other address, read data is 0x00.
- R4: A write to 0xF86 while the register is locked leaves the stored byte unchanged.
- R5: Three writes to 0xF86 in order store the third byte: 0xE7, then 0x18, then any byte. The third byte may be any value, including a key value.
- R6: After one byte has been stored, the register is locked again. A further write without a fresh key is ignored.
- R7: At 0xF86, any write other than the expected next key byte returns the sequence to its locked start. For example, 0xE7, 0xE7, 0x18 does not unlock the register. A new 0xE7 then 0x18 still unlocks it.
- R8: The two key writes never change the stored byte.
- R9: Writes to any other address change neither the stored byte nor the progress of the key sequence.
- R10: Address and data values presented with the write strobe low have no effect on the stored byte or on the key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opt_fpd_n | input | 1 | Option: 0 makes flash power-down reset to 1 |
| bus_addr | input | 12 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| int_osc_en | output | 1 | Internal oscillator enable |
| xtal_osc_en | output | 1 | Crystal oscillator enable |
| wdt_osc_en | output | 1 | Watchdog oscillator enable |
| pri_fail_det_en | output | 1 | Primary oscillator failure detection enable |
| wdt_fail_det_en | output | 1 | Watchdog oscillator failure detection enable |
| flash_pd | output | 1 | Flash power-down |
| sysclk_sel | output | 2 | System clock source select |

## Verification
The bench goes after broken key sequences and checks each failure mode at the ports:
- A repeated first key byte, which a sloppy state machine would treat as still half-open.
- A second store after an accepted one, which a design that does not re-lock would let through.
- A foreign-address write placed between the two key bytes, which a design that decodes only the data would treat as an abort.
- A key byte presented with the strobe low, which a design that ignores the strobe would count.

It reads back after each key byte, which catches a design that stores the key itself. It also resets under both option values, which catches a swapped or fixed flash power-down default.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;

  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } unlock_e;

  typedef struct packed {
    logic       int_en;
    logic       xtal_en;
    logic       wdt_en;
    logic       pri_mon_en;
    logic       wdt_mon_en;
    logic       flash_pd;
    logic [1:0] clk_src;
  } osc_fields_t;

  function automatic osc_fields_t reset_fields(input logic opt_n);
    osc_fields_t f;
    f            = '0;
    f.int_en     = 1'b1;
    f.wdt_en     = 1'b1;
    f.flash_pd   = ~opt_n;
    return f;
  endfunction

endpackage

// File: rtl/osc_addr_match.sv
module osc_addr_match #(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'hF86
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              hit,
  output logic              wr_hit
);
  always_comb begin
    hit    = (addr == REG_ADDR);
    wr_hit = hit && wr;
  end
endmodule

// File: rtl/osc_unlock_fsm.sv
module osc_unlock_fsm
  import osc_ctrl_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hE7,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output unlock_e           state,
  output logic              commit
);
  unlock_e nxt;

  always_comb begin
    nxt = state;
    if (wr_hit) begin
      case (state)
        LK_IDLE: nxt = (wdata == KEY_FIRST)  ? LK_HALF : LK_IDLE;
        LK_HALF: nxt = (wdata == KEY_SECOND) ? LK_OPEN : LK_IDLE;
        default: nxt = LK_IDLE;
      endcase
    end
  end

  always_comb commit = wr_hit && (state == LK_OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= LK_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/osc_field_store.sv
module osc_field_store
  import osc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opt_n,
  input  logic              commit,
  input  logic [DATA_W-1:0] wdata,
  output osc_fields_t       q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= reset_fields(opt_n);
    else if (commit) q <= osc_fields_t'(wdata);
  end
endmodule

// File: rtl/osc_ctrl_reg.sv
module osc_ctrl_reg
  import osc_ctrl_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 12'hF86,
  parameter logic [7:0]        KEY_FIRST  = 8'hE7,
  parameter logic [7:0]        KEY_SECOND = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opt_fpd_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              int_osc_en,
  output logic              xtal_osc_en,
  output logic              wdt_osc_en,
  output logic              pri_fail_det_en,
  output logic              wdt_fail_det_en,
  output logic              flash_pd,
  output logic [1:0]        sysclk_sel
);
  logic        hit;
  logic        wr_hit;
  logic        commit;
  unlock_e     lock_state;
  osc_fields_t reg_q;

  osc_addr_match #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) dec_i (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .hit    (hit),
    .wr_hit (wr_hit)
  );

  osc_unlock_fsm #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) fsm_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .wdata  (bus_wdata),
    .state  (lock_state),
    .commit (commit)
  );

  osc_field_store store_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .opt_n  (opt_fpd_n),
    .commit (commit),
    .wdata  (bus_wdata),
    .q      (reg_q)
  );

  always_comb begin
    bus_rdata       = hit ? reg_q : 8'h00;
    int_osc_en      = reg_q.int_en;
    xtal_osc_en     = reg_q.xtal_en;
    wdt_osc_en      = reg_q.wdt_en;
    pri_fail_det_en = reg_q.pri_mon_en;
    wdt_fail_det_en = reg_q.wdt_mon_en;
    flash_pd        = reg_q.flash_pd;
    sysclk_sel      = reg_q.clk_src;
  end
endmodule

// File: rtl/osc_ctrl_reg_chk.sv
module osc_ctrl_reg_chk
  import osc_ctrl_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 12'hF86,
  parameter logic [7:0]        KEY_SECOND = 8'h18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input unlock_e           lock_state,
  input osc_fields_t       reg_q
);
  logic own_wr;
  assign own_wr = bus_wr && (bus_addr == REG_ADDR);

  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (own_wr && lock_state != LK_OPEN) |=> $stable(reg_q));

  p_open_from_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state == LK_HALF && own_wr && bus_wdata == KEY_SECOND) |=> lock_state == LK_OPEN);

  p_relock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_wr && lock_state == LK_OPEN) |=> (lock_state == LK_IDLE && reg_q == $past(bus_wdata)));

  p_bad_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_wr && lock_state == LK_HALF && bus_wdata != KEY_SECOND) |=> lock_state == LK_IDLE);

  p_foreign_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != REG_ADDR) |=> ($stable(reg_q) && $stable(lock_state)));

  p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr) |=> ($stable(reg_q) && $stable(lock_state)));
endmodule

bind osc_ctrl_reg osc_ctrl_reg_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .KEY_SECOND(KEY_SECOND)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .lock_state (lock_state),
  .reg_q      (reg_q)
);

// File: tb/osc_ctrl_reg_tb_top.sv
module osc_ctrl_reg_tb_top;
  localparam logic [11:0] RA = 12'hF86;

  typedef struct {
    logic [7:0] val;
    logic [7:0] fld;
    string      req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opt_fpd_n = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        int_osc_en, xtal_osc_en, wdt_osc_en;
  logic        pri_fail_det_en, wdt_fail_det_en, flash_pd;
  logic [1:0]  sysclk_sel;
  logic        rd_strobe = 1'b0;

  int total = 0;
  int bad = 0;
  exp_t sb[$];

  logic [7:0] m_val;
  int         m_st;

  always #4 clk = ~clk;

  osc_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .opt_fpd_n(opt_fpd_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .int_osc_en(int_osc_en), .xtal_osc_en(xtal_osc_en),
    .wdt_osc_en(wdt_osc_en), .pri_fail_det_en(pri_fail_det_en),
    .wdt_fail_det_en(wdt_fail_det_en), .flash_pd(flash_pd),
    .sysclk_sel(sysclk_sel)
  );

  // Monitor: pops one expected item per read strobe and compares.
  always @(negedge clk) begin
    if (rd_strobe && sb.size() > 0) begin
      exp_t e;
      logic [7:0] f;
      e = sb.pop_front();
      f = {int_osc_en, xtal_osc_en, wdt_osc_en, pri_fail_det_en,
           wdt_fail_det_en, flash_pd, sysclk_sel};
      total++;
      if (bus_rdata !== e.val) begin
        bad++;
        $display("FAIL %s rdata actual=%h expected=%h", e.req, bus_rdata, e.val);
      end
      total++;
      if (f !== e.fld) begin
        bad++;
        $display("FAIL %s/R2 fields actual=%h expected=%h", e.req, f, e.fld);
      end
    end
  end

  task automatic do_reset(input logic opt);
    @(posedge clk); #1;
    opt_fpd_n = opt; rst_n = 1'b0; bus_wr = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    m_val = opt ? 8'hA0 : 8'hA4;   // R1 expected defaults
    m_st  = 0;
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d, input logic strobe = 1'b1);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = strobe;
    if (strobe && a == RA) begin
      case (m_st)
        0: m_st = (d == 8'hE7) ? 1 : 0;
        1: m_st = (d == 8'h18) ? 2 : 0;
        default: begin m_val = d; m_st = 0; end
      endcase
    end
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input string req);
    exp_t e;
    @(posedge clk); #1;
    bus_addr = a;
    e.val = (a == RA) ? m_val : 8'h00;
    e.fld = m_val;
    e.req = req;
    sb.push_back(e);
    rd_strobe = 1'b1;
    @(posedge clk); #1;
    rd_strobe = 1'b0;
  endtask

  task automatic unlock();
    bus_write(RA, 8'hE7);
    bus_write(RA, 8'h18);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    bus_read(RA, "R1");                  // R1 opt=1 -> A0
    bus_read(12'hF85, "R3");             // R3 other address reads 0
    bus_write(RA, 8'h5B);                // locked write
    bus_read(RA, "R4");                  // R4 unchanged
    bus_write(RA, 8'hE7);
    bus_read(RA, "R8");                  // R8 after first key
    bus_write(RA, 8'h18);
    bus_read(RA, "R8");                  // R8 after second key
    bus_write(RA, 8'h5B);
    bus_read(RA, "R5");                  // R5 stored
    bus_write(RA, 8'h33);
    bus_read(RA, "R6");                  // R6 relocked
    bus_write(RA, 8'hE7);
    bus_write(RA, 8'hE7);
    bus_write(RA, 8'h18);
    bus_write(RA, 8'hFF);
    bus_read(RA, "R7");                  // R7 repeated first key fails
    unlock();
    bus_write(RA, 8'h81);
    bus_read(RA, "R7");                  // R7 fresh key still works
    bus_write(RA, 8'hE7);
    bus_write(12'h123, 8'h00);
    bus_write(RA, 8'h18);
    bus_write(RA, 8'h42);
    bus_read(RA, "R9");                  // R9 foreign write did not abort
    bus_write(12'hF87, 8'h00);
    bus_read(RA, "R9");                  // R9 foreign write no store
    bus_write(RA, 8'hE7, 1'b0);
    bus_write(RA, 8'h18);
    bus_write(RA, 8'h99);
    bus_read(RA, "R10");                 // R10 strobe-low key not counted
    unlock();
    bus_write(RA, 8'hE7);
    bus_read(RA, "R5");                  // R5 key value storable as data
    bus_read(12'h000, "R3");             // R3 other address
    do_reset(1'b0);
    bus_read(RA, "R1");                  // R1 opt=0 -> A4
    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule